// File: doc/BRIEF.md
# ESF Transmission Error Event Monitor

This block watches a received T1 extended-superframe (ESF) stream and sorts each superframe's impairments into the event classes used for performance reporting. It recognises five classes: CRC-6 mismatch, severely errored framing, single framing-bit error, line-code violation and controlled slip. Framing acquisition, CRC-6 computation and B8ZS decoding happen upstream. The monitor receives their results as strobes and flags.

Each superframe is also one 3 ms observation window. The windows sit back to back and never overlap. At every superframe boundary the monitor issues one pulse per event class that occurred in the window just ended. It also keeps a saturating counter per class, which a host reads from the count ports and clears with a single strobe. The severely-errored-framing result is reported only as a performance figure. It has no link to any loss-of-frame or alarm logic.

Top module: `esf_err_mon`

## Requirements
- R1: After reset all five event pulses are low and all five counters read zero.
- R2: When `sf_strobe` is high with `crc_mismatch` high, `ev_crc` is high for exactly the one cycle after that strobe edge. `cnt_crc` then increments on the following edge.
- R3: `fbit_rx[i]` carries the framing bit of frame 4*(i+1) of the superframe. The expected values for frames 4, 8, 12, 16, 20 and 24 are 0, 0, 1, 0, 1, 1, that is `fbit_rx` equal to 6'b110100. Each bit that differs from its expected value counts as one framing-bit error.
- R4: A superframe with two or more framing-bit errors raises `ev_sef` one cycle after its strobe, and `cnt_sef` increments on the following edge.
- R5: A superframe with exactly one framing-bit error raises `ev_fbe` instead, and `cnt_fbe` increments. `ev_sef` and `ev_fbe` are never high together.
- R6: A line-code violation occurrence is a cycle with `exz` high, or with `bpv` high and `bpv_in_code` low. `cnt_lcv` increments on every such cycle. A `bpv` flagged as part of a substitution code changes neither `cnt_lcv` nor `ev_lcv`.
- R7: `cnt_slip` increments on every cycle with `slip` high.
- R8: Event pulses appear only in the cycle after an `sf_strobe`. `ev_lcv` and `ev_slip` report whether any occurrence happened since the previous strobe, including the strobe cycle itself. Each strobe starts a fresh window.
- R9: Every counter holds at all ones once it gets there (15 with the bench's 4-bit width).
- R10: `cnt_clr` sets all counters to zero. In a cycle where a counter also increments, that counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_strobe | input | 1 | Superframe boundary; `fbit_rx` and `crc_mismatch` are valid with it |
| fbit_rx | input | 6 | Received framing bits, bit i from frame 4*(i+1) |
| crc_mismatch | input | 1 | Received CRC-6 differs from the locally computed one |
| bpv | input | 1 | Bipolar violation pulse from the line decoder |
| bpv_in_code | input | 1 | Marks the current `bpv` as part of a valid zero-substitution code |
| exz | input | 1 | Excessive-zeros pulse |
| slip | input | 1 | Controlled slip pulse (frame repeated or deleted) |
| cnt_clr | input | 1 | Host clear strobe for all counters |
| ev_crc | output | 1 | CRC error event pulse |
| ev_sef | output | 1 | Severely errored framing event pulse |
| ev_fbe | output | 1 | Single framing-bit error event pulse |
| ev_lcv | output | 1 | Line-code violation event pulse |
| ev_slip | output | 1 | Controlled slip event pulse |
| cnt_crc | output | CNT_W | CRC error event count |
| cnt_sef | output | CNT_W | Severely errored framing count |
| cnt_fbe | output | CNT_W | Framing-bit error count |
| cnt_lcv | output | CNT_W | Line-code violation count |
| cnt_slip | output | CNT_W | Controlled slip count |

## Verification
The bench builds the monitor with `CNT_W = 4`. With that width the all-ones hold point is 15, so a short burst of slip pulses drives a counter into saturation and keeps it there. The shipped 16-bit width would instead need more than 65,000 events. The threshold of two framing errors keeps its default value. That default leaves room for the cases of zero, one, two and six mismatched bits, and for two windows in a row with one error each.

// File: rtl/esf_mon_pkg.sv
package esf_mon_pkg;
  localparam int NUM_FBITS = 6;
  // Expected framing bits, bit i = frame 4*(i+1): 0,0,1,0,1,1
  localparam logic [NUM_FBITS-1:0] FBIT_EXPECT = 6'b110100;

  localparam int EV_CRC  = 0;
  localparam int EV_SEF  = 1;
  localparam int EV_FBE  = 2;
  localparam int EV_LCV  = 3;
  localparam int EV_SLIP = 4;
  localparam int NUM_EV  = 5;

  localparam int ERR_CNT_W = $clog2(NUM_FBITS + 1);

  // Number of framing bits that disagree with the expected pattern
  function automatic logic [ERR_CNT_W-1:0] fbit_errors(logic [NUM_FBITS-1:0] rx);
    logic [ERR_CNT_W-1:0] n;
    logic [NUM_FBITS-1:0] diff;
    diff = rx ^ FBIT_EXPECT;
    n = '0;
    for (int i = 0; i < NUM_FBITS; i++) begin
      n = n + ERR_CNT_W'(diff[i]);
    end
    return n;
  endfunction
endpackage

// File: rtl/esf_fbit_check.sv
module esf_fbit_check
  import esf_mon_pkg::*;
#(
  parameter int SEF_MIN = 2
) (
  input  logic [NUM_FBITS-1:0] fbit_rx,
  output logic [ERR_CNT_W-1:0] err_cnt,
  output logic                 sef_hit,
  output logic                 fbe_hit
);
  localparam logic [ERR_CNT_W-1:0] SEF_MIN_L = ERR_CNT_W'(SEF_MIN);

  always_comb begin
    err_cnt = fbit_errors(fbit_rx);
    sef_hit = (err_cnt >= SEF_MIN_L);
    fbe_hit = (err_cnt != '0) && !sef_hit;
  end
endmodule

// File: rtl/esf_occ_acc.sv
module esf_occ_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic occ,
  input  logic sf_strobe,
  output logic any_in_sf
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else if (sf_strobe) begin
      seen_q <= 1'b0;
    end else if (occ) begin
      seen_q <= 1'b1;
    end
  end

  assign any_in_sf = seen_q | occ;
endmodule

// File: rtl/esf_sat_cnt.sv
module esf_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  function automatic logic [W-1:0] next_count(logic [W-1:0] cur, logic up, logic wipe);
    logic [W-1:0] base;
    base = wipe ? '0 : cur;
    if (up && base != CNT_MAX) begin
      return base + W'(1);
    end
    return base;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= next_count(cnt, inc, clr);
    end
  end
endmodule

// File: rtl/esf_err_mon.sv
module esf_err_mon
  import esf_mon_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int SEF_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_strobe,
  input  logic [5:0]       fbit_rx,
  input  logic             crc_mismatch,
  input  logic             bpv,
  input  logic             bpv_in_code,
  input  logic             exz,
  input  logic             slip,
  input  logic             cnt_clr,
  output logic             ev_crc,
  output logic             ev_sef,
  output logic             ev_fbe,
  output logic             ev_lcv,
  output logic             ev_slip,
  output logic [CNT_W-1:0] cnt_crc,
  output logic [CNT_W-1:0] cnt_sef,
  output logic [CNT_W-1:0] cnt_fbe,
  output logic [CNT_W-1:0] cnt_lcv,
  output logic [CNT_W-1:0] cnt_slip
);
  logic [ERR_CNT_W-1:0]         fb_err_cnt;
  logic                         sef_hit;
  logic                         fbe_hit;
  logic                         lcv_occ;
  logic                         lcv_in_sf;
  logic                         slip_in_sf;
  logic [NUM_EV-1:0]            ev_vec;
  logic [NUM_EV-1:0]            ev_next;
  logic [NUM_EV-1:0]            inc_vec;
  logic [NUM_EV-1:0][CNT_W-1:0] cnt_arr;

  assign lcv_occ = exz | (bpv & ~bpv_in_code);

  esf_fbit_check #(.SEF_MIN(SEF_MIN)) u_fchk (
    .fbit_rx (fbit_rx),
    .err_cnt (fb_err_cnt),
    .sef_hit (sef_hit),
    .fbe_hit (fbe_hit)
  );

  esf_occ_acc u_lcv_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ       (lcv_occ),
    .sf_strobe (sf_strobe),
    .any_in_sf (lcv_in_sf)
  );

  esf_occ_acc u_slip_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ       (slip),
    .sf_strobe (sf_strobe),
    .any_in_sf (slip_in_sf)
  );

  always_comb begin
    ev_next          = '0;
    ev_next[EV_CRC]  = crc_mismatch;
    ev_next[EV_SEF]  = sef_hit;
    ev_next[EV_FBE]  = fbe_hit;
    ev_next[EV_LCV]  = lcv_in_sf;
    ev_next[EV_SLIP] = slip_in_sf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_vec <= '0;
    end else begin
      ev_vec <= sf_strobe ? ev_next : '0;
    end
  end

  // Window events count once per superframe; line and slip events per occurrence
  always_comb begin
    inc_vec          = ev_vec;
    inc_vec[EV_LCV]  = lcv_occ;
    inc_vec[EV_SLIP] = slip;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    esf_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc_vec[g]),
      .clr   (cnt_clr),
      .cnt   (cnt_arr[g])
    );
  end

  assign ev_crc   = ev_vec[EV_CRC];
  assign ev_sef   = ev_vec[EV_SEF];
  assign ev_fbe   = ev_vec[EV_FBE];
  assign ev_lcv   = ev_vec[EV_LCV];
  assign ev_slip  = ev_vec[EV_SLIP];
  assign cnt_crc  = cnt_arr[EV_CRC];
  assign cnt_sef  = cnt_arr[EV_SEF];
  assign cnt_fbe  = cnt_arr[EV_FBE];
  assign cnt_lcv  = cnt_arr[EV_LCV];
  assign cnt_slip = cnt_arr[EV_SLIP];
endmodule

// File: rtl/esf_err_mon_chk.sv
module esf_err_mon_chk
  import esf_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         sf_strobe,
  input logic                         crc_mismatch,
  input logic                         bpv,
  input logic                         bpv_in_code,
  input logic                         exz,
  input logic                         cnt_clr,
  input logic [NUM_EV-1:0]            ev_vec,
  input logic [NUM_EV-1:0]            inc_vec,
  input logic [NUM_EV-1:0][CNT_W-1:0] cnt_arr
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  a_r8_ev_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |-> $past(sf_strobe));

  a_r2_crc_event: assert property (@(posedge clk) disable iff (!rst_n)
    (sf_strobe && crc_mismatch) |=> ev_vec[EV_CRC]);

  a_r5_sef_fbe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_vec[EV_SEF], ev_vec[EV_FBE]}));

  a_r6_coded_bpv_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv && bpv_in_code && !exz && !cnt_clr) |=> $stable(cnt_arr[EV_LCV]));

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt_chk
    a_r9_hold_max: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_arr[g] == MAXV && !cnt_clr) |=> cnt_arr[g] == MAXV);

    a_r10_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && !inc_vec[g]) |=> cnt_arr[g] == '0);

    a_r10_clear_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && inc_vec[g]) |=> cnt_arr[g] == CNT_W'(1));

    a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_clr && inc_vec[g] && cnt_arr[g] != MAXV) |=> cnt_arr[g] == $past(cnt_arr[g]) + CNT_W'(1));
  end
endmodule

bind esf_err_mon esf_err_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sf_strobe    (sf_strobe),
  .crc_mismatch (crc_mismatch),
  .bpv          (bpv),
  .bpv_in_code  (bpv_in_code),
  .exz          (exz),
  .cnt_clr      (cnt_clr),
  .ev_vec       (ev_vec),
  .inc_vec      (inc_vec),
  .cnt_arr      (cnt_arr)
);

// File: tb/esf_err_mon_tb.sv
module esf_err_mon_tb;
  localparam int W = 4;
  localparam int MAXC = 15;
  localparam logic [5:0] GOOD = 6'b110100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sf_strobe = 1'b0, crc_mismatch = 1'b0, bpv = 1'b0, bpv_in_code = 1'b0;
  logic exz = 1'b0, slip = 1'b0, cnt_clr = 1'b0;
  logic [5:0] fbit_rx = GOOD;
  logic ev_crc, ev_sef, ev_fbe, ev_lcv, ev_slip;
  logic [W-1:0] cnt_crc, cnt_sef, cnt_fbe, cnt_lcv, cnt_slip;

  int n_chk = 0, n_fail = 0;
  int e_crc = 0, e_sef = 0, e_fbe = 0, e_lcv = 0, e_slip = 0;

  always #4 clk = ~clk;

  esf_err_mon #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .fbit_rx(fbit_rx),
    .crc_mismatch(crc_mismatch), .bpv(bpv), .bpv_in_code(bpv_in_code),
    .exz(exz), .slip(slip), .cnt_clr(cnt_clr),
    .ev_crc(ev_crc), .ev_sef(ev_sef), .ev_fbe(ev_fbe), .ev_lcv(ev_lcv), .ev_slip(ev_slip),
    .cnt_crc(cnt_crc), .cnt_sef(cnt_sef), .cnt_fbe(cnt_fbe), .cnt_lcv(cnt_lcv), .cnt_slip(cnt_slip)
  );

  function automatic int sat(int v);
    return (v >= MAXC) ? MAXC : v + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(string req);
    chk({req, " cnt_crc"},  int'(cnt_crc),  e_crc);
    chk({req, " cnt_sef"},  int'(cnt_sef),  e_sef);
    chk({req, " cnt_fbe"},  int'(cnt_fbe),  e_fbe);
    chk({req, " cnt_lcv"},  int'(cnt_lcv),  e_lcv);
    chk({req, " cnt_slip"}, int'(cnt_slip), e_slip);
  endtask

  // Close one superframe; check pulses the cycle after, counters the cycle after that
  task automatic superframe(string req, logic [5:0] fb, logic crc,
                            int x_crc, int x_sef, int x_fbe, int x_lcv, int x_slip);
    @(negedge clk);
    sf_strobe = 1'b1; fbit_rx = fb; crc_mismatch = crc;
    @(negedge clk);
    sf_strobe = 1'b0; fbit_rx = GOOD; crc_mismatch = 1'b0;
    chk({req, " ev_crc"},  int'(ev_crc),  x_crc);
    chk({req, " ev_sef"},  int'(ev_sef),  x_sef);
    chk({req, " ev_fbe"},  int'(ev_fbe),  x_fbe);
    chk({req, " ev_lcv"},  int'(ev_lcv),  x_lcv);
    chk({req, " ev_slip"}, int'(ev_slip), x_slip);
    if (x_crc != 0) e_crc = sat(e_crc);
    if (x_sef != 0) e_sef = sat(e_sef);
    if (x_fbe != 0) e_fbe = sat(e_fbe);
    @(negedge clk);
    chk({req, " pulse drop ev_crc"}, int'(ev_crc | ev_sef | ev_fbe | ev_lcv | ev_slip), 0);
    chk_counts(req);
  endtask

  task automatic line_pulse(logic b, logic code, logic z, logic s);
    @(negedge clk);
    bpv = b; bpv_in_code = code; exz = z; slip = s;
    @(negedge clk);
    bpv = 1'b0; bpv_in_code = 1'b0; exz = 1'b0; slip = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ev any", int'(ev_crc | ev_sef | ev_fbe | ev_lcv | ev_slip), 0);
    chk_counts("R1");
  endtask

  task automatic t_crc();
    superframe("R2 crc err", GOOD, 1'b1, 1, 0, 0, 0, 0);
    superframe("R2 crc ok",  GOOD, 1'b0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_pattern();
    superframe("R3 exact pattern", GOOD, 1'b0, 0, 0, 0, 0, 0);
    superframe("R3 R5 frame12 flipped", GOOD ^ 6'b000100, 1'b0, 0, 0, 1, 0, 0);
    superframe("R3 R5 frame24 flipped", GOOD ^ 6'b100000, 1'b0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_sef();
    superframe("R4 two errors", GOOD ^ 6'b000011, 1'b0, 0, 1, 0, 0, 0);
    superframe("R4 six errors", ~GOOD, 1'b1, 1, 1, 0, 0, 0);
  endtask

  task automatic t_window();
    superframe("R8 window A one err", GOOD ^ 6'b001000, 1'b0, 0, 0, 1, 0, 0);
    superframe("R8 window B one err", GOOD ^ 6'b010000, 1'b0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_lcv();
    line_pulse(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R6 coded bpv ignored", int'(cnt_lcv), e_lcv);
    superframe("R6 coded bpv no event", GOOD, 1'b0, 0, 0, 0, 0, 0);
    line_pulse(1'b1, 1'b0, 1'b0, 1'b0); e_lcv = sat(e_lcv);
    chk("R6 bare bpv", int'(cnt_lcv), e_lcv);
    line_pulse(1'b0, 1'b0, 1'b1, 1'b0); e_lcv = sat(e_lcv);
    chk("R6 exz", int'(cnt_lcv), e_lcv);
    line_pulse(1'b1, 1'b0, 1'b1, 1'b0); e_lcv = sat(e_lcv);
    chk("R6 bpv+exz one occurrence", int'(cnt_lcv), e_lcv);
    superframe("R6 lcv event", GOOD, 1'b0, 0, 0, 0, 1, 0);
    superframe("R8 lcv fresh window", GOOD, 1'b0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_slip();
    for (int i = 0; i < 3; i++) begin
      line_pulse(1'b0, 1'b0, 1'b0, 1'b1); e_slip = sat(e_slip);
    end
    chk("R7 three slips", int'(cnt_slip), e_slip);
    superframe("R7 slip event", GOOD, 1'b0, 0, 0, 0, 0, 1);
    // Slip on the strobe cycle belongs to the closing window
    @(negedge clk);
    sf_strobe = 1'b1; slip = 1'b1;
    @(negedge clk);
    sf_strobe = 1'b0; slip = 1'b0; e_slip = sat(e_slip);
    chk("R8 slip at boundary ev", int'(ev_slip), 1);
    chk("R7 slip at boundary cnt", int'(cnt_slip), e_slip);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) begin
      line_pulse(1'b0, 1'b0, 1'b0, 1'b1); e_slip = sat(e_slip);
    end
    chk("R9 saturate slip", int'(cnt_slip), MAXC);
    chk("R9 model", e_slip, MAXC);
    superframe("R9 flush", GOOD, 1'b0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_clear();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    e_crc = 0; e_sef = 0; e_fbe = 0; e_lcv = 0; e_slip = 0;
    chk_counts("R10 clear");
    @(negedge clk); cnt_clr = 1'b1; slip = 1'b1;
    @(negedge clk); cnt_clr = 1'b0; slip = 1'b0;
    chk("R10 clear+slip", int'(cnt_slip), 1);
    @(negedge clk); sf_strobe = 1'b1; crc_mismatch = 1'b1;
    @(negedge clk); sf_strobe = 1'b0; crc_mismatch = 1'b0; cnt_clr = 1'b1;
    chk("R2 ev_crc before clear", int'(ev_crc), 1);
    @(negedge clk); cnt_clr = 1'b0;
    chk("R10 clear+crc event", int'(cnt_crc), 1);
    chk("R10 slip cleared", int'(cnt_slip), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_crc();
    t_pattern();
    t_sef();
    t_window();
    t_lcv();
    t_slip();
    t_sat();
    t_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule